// File: doc/BRIEF.md
# Dual External Interrupt Edge Controller

This block watches two external interrupt pins. Each pin passes through a two-flop synchronizer. An edge detector then compares the current synchronized sample with the one before it. A 2-bit selector per channel picks the edge that counts: rising, falling, both, or none. A qualifying edge sets the request flag of that channel. The flag is set even when the channel's enable bit is clear, so software can poll the flag. The same edge also pulses a wake output toward the power controller, so a sleeping system restarts with the flag already latched.

The block drives a single interrupt request toward a fixed vector address. The request is raised only while the global enable is set and at least one channel has both its flag and its enable set. Software configures and observes the block through a plain single-cycle register port. Reads are combinational and writes take effect at the clock edge. Writing 0 to a flag bit clears it. The block carries no data stream, so the register port has no valid/ready handshake. A write is always accepted in the cycle it is presented.

Top module: `ext_irq_edge_ctrl`

## Requirements
- R1: After reset, the edge-select register reads 0x0A and the enable register reads 0x00. The flag register also reads 0x00, and irq_o and wake_o are 0.
- R2: The edge-select register is at address 0xBF. Bits [1:0] hold the channel 0 selector and bits [3:2] hold the channel 1 selector. Bits [7:4] ignore writes and always read 0.
- R3: Selector 01 qualifies a rising edge, 10 a falling edge and 11 either edge. A pin change presented before clock edge k sets the flag at clock edge k+2. Edges of the other polarity do not set the flag.
- R4: Selector 00 never sets the flag of its channel and never raises wake_o.
- R5: A qualifying edge sets the channel flag whatever the state of the channel enable and the global enable.
- R6: The enable register is at address 0xC0, with bit 0 for channel 0, bit 1 for channel 1 and bit 7 as the global enable. irq_o is 1 exactly when the global enable is 1 and some channel has both its flag and its enable at 1. vector_o is constantly 8.
- R7: wake_o is 1 for exactly one cycle per qualifying edge, in the cycle just before the flag sets. This holds regardless of any enable bit.
- R8: The flag register is at address 0xC1, with bit 0 for channel 0 and bit 1 for channel 1. Writing 0 to a bit clears that flag and writing 1 leaves it unchanged. If a qualifying edge and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R9: A pin held at a constant level after an edge does not set the flag again once it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 2 | Asynchronous external interrupt pins, bit n for channel n |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for read and write |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Combinational read data for addr |
| irq_o | output | 1 | Interrupt request toward the vector |
| vector_o | output | 8 | Fixed vector address (8) |
| wake_o | output | 1 | One-cycle wake pulse on any qualifying edge |

## Verification
Two actions can reach the same flag bit in one cycle: the hardware setting it on a detected edge, and a software write clearing it. The bench provokes the overlap by toggling a pin and counting two clock edges. It then presents a clearing write to the flag register, so the write lands on the exact clock edge where the detected edge sets the flag. The flag is read back afterwards and must be 1, because the edge must not be lost. A checker assertion also requires that every wake pulse is followed by a set flag.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_i,
  output logic [NCH-1:0] cur_o,
  output logic [NCH-1:0] prev_o
);
  logic [NCH-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/eirq_edge_det.sv
module eirq_edge_det
  import ext_irq_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       cur_i,
  input  logic       prev_i,
  output logic       hit_o
);
  logic rise, fall;
  assign rise = cur_i & ~prev_i;
  assign fall = ~cur_i & prev_i;

  always_comb begin
    unique case (edge_mode_e'(sel_i))
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_ANY:  hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs #(
  parameter int          NCH        = 2,
  parameter int          AW         = 8,
  parameter int          DW         = 8,
  parameter logic [AW-1:0] EDGE_ADDR = 8'hBF,
  parameter logic [AW-1:0] EN_ADDR   = 8'hC0,
  parameter logic [AW-1:0] FLAG_ADDR = 8'hC1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [NCH-1:0]   hit_i,
  output logic [DW-1:0]    rdata,
  output logic [2*NCH-1:0] sel_o,
  output logic [NCH-1:0]   en_o,
  output logic             gie_o,
  output logic [NCH-1:0]   flag_o
);
  localparam int SW = 2 * NCH;
  localparam logic [SW-1:0] SEL_RST = {NCH{2'b10}};

  logic [SW-1:0]  sel_q;
  logic [NCH-1:0] en_q, flag_q, flag_n;
  logic           gie_q;
  logic           wr_sel, wr_en_reg, wr_flag;

  assign wr_sel    = wr_en && (addr == EDGE_ADDR);
  assign wr_en_reg = wr_en && (addr == EN_ADDR);
  assign wr_flag   = wr_en && (addr == FLAG_ADDR);

  // Software clears first, then hardware sets on top: set wins.
  always_comb begin
    flag_n = flag_q;
    if (wr_flag) flag_n = flag_q & wdata[NCH-1:0];
    flag_n = flag_n | hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= SEL_RST;
      en_q   <= '0;
      gie_q  <= 1'b0;
      flag_q <= '0;
    end else begin
      if (wr_sel) sel_q <= wdata[SW-1:0];
      if (wr_en_reg) begin
        en_q  <= wdata[NCH-1:0];
        gie_q <= wdata[DW-1];
      end
      flag_q <= flag_n;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == EDGE_ADDR)      rdata[SW-1:0]  = sel_q;
    else if (addr == EN_ADDR) begin
      rdata[NCH-1:0] = en_q;
      rdata[DW-1]    = gie_q;
    end
    else if (addr == FLAG_ADDR) rdata[NCH-1:0] = flag_q;
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  assign sel_o  = sel_q;
  assign en_o   = en_q;
  assign gie_o  = gie_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/ext_irq_edge_ctrl.sv
module ext_irq_edge_ctrl #(
  parameter int            NCH       = 2,
  parameter int            AW        = 8,
  parameter int            DW        = 8,
  parameter logic [AW-1:0] EDGE_ADDR = 8'hBF,
  parameter logic [AW-1:0] EN_ADDR   = 8'hC0,
  parameter logic [AW-1:0] FLAG_ADDR = 8'hC1,
  parameter logic [AW-1:0] VECTOR    = 8'h08
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_i,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic           irq_o,
  output logic [AW-1:0]  vector_o,
  output logic           wake_o
);
  logic [NCH-1:0]   cur, prev, hit, en, flag;
  logic [2*NCH-1:0] edge_q;
  logic             gie;

  eirq_sync #(.NCH(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cur_o(cur), .prev_o(prev)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_det
    eirq_edge_det u_det (
      .sel_i (edge_q[2*c +: 2]),
      .cur_i (cur[c]),
      .prev_i(prev[c]),
      .hit_o (hit[c])
    );
  end

  eirq_regs #(
    .NCH(NCH), .AW(AW), .DW(DW),
    .EDGE_ADDR(EDGE_ADDR), .EN_ADDR(EN_ADDR), .FLAG_ADDR(FLAG_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .hit_i(hit), .rdata(rdata), .sel_o(edge_q), .en_o(en), .gie_o(gie),
    .flag_o(flag)
  );

  assign irq_o    = gie & (|(flag & en));
  assign wake_o   = |hit;
  assign vector_o = VECTOR;
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk #(
  parameter int            NCH       = 2,
  parameter int            AW        = 8,
  parameter int            DW        = 8,
  parameter logic [AW-1:0] FLAG_ADDR = 8'hC1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   hit,
  input logic [NCH-1:0]   flag,
  input logic [NCH-1:0]   en,
  input logic             gie,
  input logic [2*NCH-1:0] sel,
  input logic             irq_o,
  input logic             wake_o,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wdata
);
  // R6
  irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_o);

  // R6
  irq_needs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(flag & en)));

  // R7
  wake_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> (flag != '0));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // R4
    no_reserved_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[c]) |-> ($past(sel[2*c +: 2]) != 2'b00));

    // R3
    flag_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[c]) |-> $past(hit[c]));

    // R8
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == FLAG_ADDR && !wdata[c] && !hit[c]) |=> !flag[c]);
  end
endmodule

bind ext_irq_edge_ctrl eirq_chk #(
  .NCH(NCH), .AW(AW), .DW(DW), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit), .flag(flag), .en(en), .gie(gie),
  .sel(edge_q), .irq_o(irq_o), .wake_o(wake_o), .wr_en(wr_en),
  .addr(addr), .wdata(wdata)
);

// File: tb/tb_ext_irq_edge_ctrl.sv
module tb_ext_irq_edge_ctrl;
  localparam int CLK_P = 10;
  localparam logic [7:0] A_EDGE = 8'hBF, A_EN = 8'hC0, A_FLAG = 8'hC1;

  logic       clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] pin_i = 2'b00;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata, vector_o;
  logic       irq_o, wake_o;
  int         n_run = 0, n_fail = 0;
  logic [7:0] rv;

  ext_irq_edge_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .vector_o(vector_o),
    .wake_o(wake_o)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  // Change a pin, check wake two edges later and the flag one edge after.
  task automatic edge_chk(input int ch, input logic v, input logic exp, input string tag);
    logic wk;
    logic [7:0] f;
    pin_i[ch] = v;
    @(negedge clk); @(negedge clk);
    wk = wake_o;
    chk(wk == exp, {tag, " wake"}, wk, exp);
    @(negedge clk);
    rd(A_FLAG, f);
    chk(f[ch] == exp, {tag, " flag"}, f[ch], exp);
    @(negedge clk);
    chk(wake_o == 0, {tag, " wake once R7"}, wake_o, 0);
  endtask

  task automatic t_reset;
    rd(A_EDGE, rv); chk(rv == 8'h0A, "R1 edge reg", rv, 8'h0A);
    rd(A_EN, rv);   chk(rv == 8'h00, "R1 en reg", rv, 0);
    rd(A_FLAG, rv); chk(rv == 8'h00, "R1 flag reg", rv, 0);
    chk(irq_o == 0 && wake_o == 0, "R1 irq/wake", {irq_o, wake_o}, 0);
    chk(vector_o == 8'h08, "R6 vector", vector_o, 8);
  endtask

  task automatic t_regmap;
    wr(A_EDGE, 8'hF7);
    rd(A_EDGE, rv); chk(rv == 8'h07, "R2 upper bits ignored", rv, 8'h07);
    wr(A_EDGE, 8'h0A);
  endtask

  task automatic t_fall;
    edge_chk(0, 1'b1, 1'b0, "R3 fall ignores rise");
    edge_chk(0, 1'b0, 1'b1, "R3 R5 fall sets disabled");
    chk(irq_o == 0, "R6 no irq when disabled", irq_o, 0);
    wr(A_FLAG, 8'h00);
  endtask

  task automatic t_rise;
    wr(A_EDGE, 8'h04);
    edge_chk(1, 1'b1, 1'b1, "R3 rise ch1");
    wr(A_FLAG, 8'h00);
    edge_chk(1, 1'b0, 1'b0, "R3 rise ignores fall");
  endtask

  task automatic t_any_and_reserved;
    wr(A_EDGE, 8'h03);
    edge_chk(0, 1'b1, 1'b1, "R3 any rise");
    wr(A_FLAG, 8'h00);
    edge_chk(0, 1'b0, 1'b1, "R3 any fall");
    wr(A_FLAG, 8'h00);
    wr(A_EDGE, 8'h00);
    edge_chk(0, 1'b1, 1'b0, "R4 reserved rise");
    edge_chk(0, 1'b0, 1'b0, "R4 reserved fall");
  endtask

  task automatic t_irq;
    wr(A_EDGE, 8'h0F);
    edge_chk(0, 1'b1, 1'b1, "R5 set before enable");
    wr(A_EN, 8'h80); #1;
    chk(irq_o == 0, "R6 gie only", irq_o, 0);
    wr(A_EN, 8'h01); #1;
    chk(irq_o == 0, "R6 en only", irq_o, 0);
    wr(A_EN, 8'h81); #1;
    chk(irq_o == 1, "R6 gie+en+flag", irq_o, 1);
    wr(A_EN, 8'h82); #1;
    chk(irq_o == 0, "R6 other channel en", irq_o, 0);
    wr(A_EN, 8'h81);
    wr(A_FLAG, 8'h00); #1;
    chk(irq_o == 0, "R8 clear drops irq", irq_o, 0);
    wr(A_EN, 8'h00);
  endtask

  task automatic t_clear_mask;
    edge_chk(1, 1'b1, 1'b1, "R8 prep ch1");
    edge_chk(0, 1'b0, 1'b1, "R8 prep ch0");
    wr(A_FLAG, 8'h02);
    rd(A_FLAG, rv); chk(rv == 8'h02, "R8 write-1 keeps", rv, 8'h02);
    wr(A_FLAG, 8'h00);
  endtask

  task automatic t_collision;
    pin_i[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(A_FLAG, 8'h00);
    rd(A_FLAG, rv); chk(rv[0] == 1'b1, "R8 set beats clear", rv[0], 1);
    wr(A_FLAG, 8'h00);
  endtask

  task automatic t_hold;
    wr(A_FLAG, 8'h00);
    repeat (6) @(negedge clk);
    rd(A_FLAG, rv); chk(rv == 8'h00, "R9 held level no reset", rv, 0);
    chk(wake_o == 0, "R9 held level no wake", wake_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_regmap;
    t_fall;
    t_rise;
    t_any_and_reserved;
    t_irq;
    t_clear_mask;
    t_collision;
    t_hold;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule